// File: doc/BRIEF.md
# Ratio-Checked Multi-Domain Strobe Divider

This block turns one fast reference clock into five synchronous clock-enable strobes. The domains are core, bus, peripheral, fast timer and slow timer. Every domain divides the same reference by its own ratio, never another domain's output. Each ratio is chosen from 1, 2, 3, 4 or 8. Logic in a domain runs on the reference clock and advances only in cycles where that domain's strobe is high. A board-level clock output `ext_clk_o` runs at the bus domain rate.

Software programs all five ratios with one control word. Before the block accepts a word, it checks two things: that every code is defined, and that the domain frequencies keep their required ordering. A rejected word leaves the running ratios unchanged and raises a sticky error flag. An accepted word waits in a pending register. All five domains switch to it together on the first reference cycle in which every divider sits at count zero. This keeps the strobes of all domains phase-aligned.

Top module: `ratio_clock_divider`

## Requirements
- R1: Reset sets every domain to divide-by-8 with its counter at zero and clears the error flag. All five strobes are therefore high in the first cycle after reset, and next high eight cycles later.
- R2: A domain with ratio N raises its strobe for exactly one reference cycle out of every N, starting at count zero. Ratio 1 holds the strobe high continuously. Each domain's ratio is a 3-bit code: 000 gives 1, 001 gives 2, 010 gives 3, 011 gives 4 and 100 gives 8.
- R3: All domains count the same reference. After a new setting is applied, every strobe is high together in the apply cycle, and each strobe then keeps its own period.
- R4: An accepted word is applied to all domains at once, on the first clock edge after it is written at which every counter is zero. A second accepted word written before that edge replaces the first.
- R5: A word that holds a reserved code (101, 110 or 111) in any field is rejected. The error flag is set and the running ratios stay as they were.
- R6: A word in which the bus ratio is smaller than the core ratio (bus faster than core) is rejected and sets the error flag.
- R7: A word in which the peripheral ratio is smaller than the bus ratio is rejected and sets the error flag.
- R8: The fast timer ratio must be at least the core ratio and at most the slow timer ratio. Otherwise the word is rejected and sets the error flag.
- R9: The slow timer ratio must be at least the bus ratio and at most the peripheral ratio. Otherwise the word is rejected and sets the error flag.
- R10: The error flag stays set until a write to address 1 with data bit 0 equal to 1. A write to address 1 with bit 0 equal to 0 leaves it unchanged.
- R11: `ext_clk_o` has the bus period. It is high for the first ceil(N/2) cycles of each bus period, starting in the cycle where the bus strobe is high. With bus ratio 1 it is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | 1 | 0 = ratio word, 1 = error clear |
| cfg_wdata | input | 15 | Ratio word. Bits [2:0] core, [5:3] bus, [8:6] peripheral, [11:9] fast timer, [14:12] slow timer. At address 1, bit 0 = 1 clears the error flag |
| strobe_o | output | 5 | Enable strobes. Bit 0 core, 1 bus, 2 peripheral, 3 fast timer, 4 slow timer |
| ext_clk_o | output | 1 | External clock at the bus domain rate |
| cfg_err_o | output | 1 | Sticky rejected-write flag |

## Verification
The bench builds the block with its default parameter, so reset starts every domain at divide-by-8. This default makes the longest realignment window reachable: the reset state, a mixed /1–/2–/4 setting and a /3–/4–/8 setting. That window runs 24 cycles between common zero points, which gives a pending word time to be replaced before it is applied. Against this state the bench tries one violating word per ordering rule, a reserved code, and the clear write with bit 0 both set and cleared.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

    localparam int NDOM   = 5;
    localparam int CODE_W = 3;
    localparam int MAXDIV = 8;
    localparam int CNT_W  = $clog2(MAXDIV);
    localparam int DIV_W  = CNT_W + 1;
    localparam int CFG_W  = NDOM * CODE_W;

    localparam int D_CORE  = 0;
    localparam int D_BUS   = 1;
    localparam int D_PERI  = 2;
    localparam int D_TFAST = 3;
    localparam int D_TSLOW = 4;

    typedef logic [CODE_W-1:0] code_t;
    typedef code_t [NDOM-1:0]  cfg_t;
    typedef logic [DIV_W-1:0]  div_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum code_t {
        SEL_DIV1 = 3'b000,
        SEL_DIV2 = 3'b001,
        SEL_DIV3 = 3'b010,
        SEL_DIV4 = 3'b011,
        SEL_DIV8 = 3'b100
    } div_sel_e;

    typedef struct packed {
        cfg_t cfg;
        logic valid;
    } pend_t;

    function automatic logic code_defined(code_t c);
        return c <= code_t'(SEL_DIV8);
    endfunction

    function automatic div_t code_div(code_t c);
        case (c)
            code_t'(SEL_DIV1): return div_t'(1);
            code_t'(SEL_DIV2): return div_t'(2);
            code_t'(SEL_DIV3): return div_t'(3);
            code_t'(SEL_DIV4): return div_t'(4);
            default:           return div_t'(MAXDIV);
        endcase
    endfunction

    function automatic cnt_t code_last(code_t c);
        div_t d;
        d = code_div(c) - div_t'(1);
        return d[CNT_W-1:0];
    endfunction

    function automatic div_t code_half(code_t c);
        div_t d;
        d = code_div(c) + div_t'(1);
        return d >> 1;
    endfunction

endpackage

// File: rtl/ckdiv_rule_check.sv
module ckdiv_rule_check
    import ckdiv_pkg::*;
(
    input  cfg_t cand,
    output logic legal,
    output logic codes_ok,
    output logic order_ok
);
    logic [NDOM-1:0] field_ok;
    div_t            dv [NDOM];

    for (genvar i = 0; i < NDOM; i++) begin : g_field
        assign field_ok[i] = code_defined(cand[i]);
        assign dv[i]       = code_div(cand[i]);
    end

    logic bus_vs_core, peri_vs_bus, tfast_lo, tfast_hi, tslow_lo, tslow_hi;

    always_comb begin
        bus_vs_core = dv[D_BUS]   >= dv[D_CORE];
        peri_vs_bus = dv[D_PERI]  >= dv[D_BUS];
        tfast_lo    = dv[D_TFAST] >= dv[D_CORE];
        tfast_hi    = dv[D_TFAST] <= dv[D_TSLOW];
        tslow_lo    = dv[D_TSLOW] >= dv[D_BUS];
        tslow_hi    = dv[D_TSLOW] <= dv[D_PERI];
    end

    assign codes_ok = &field_ok;
    assign order_ok = bus_vs_core & peri_vs_bus & tfast_lo & tfast_hi
                    & tslow_lo & tslow_hi;
    assign legal    = codes_ok & order_ok;
endmodule

// File: rtl/ckdiv_cfg_ctrl.sv
module ckdiv_cfg_ctrl
    import ckdiv_pkg::*;
#(
    parameter code_t RST_CODE = SEL_DIV8
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_we,
    input  logic cfg_addr,
    input  cfg_t wr_cfg,
    input  logic wr_clr,
    input  logic wr_legal,
    input  logic all_zero,
    output cfg_t act_cfg,
    output cfg_t use_cfg,
    output logic apply,
    output logic err
);
    pend_t pend_q;
    cfg_t  act_q;
    logic  err_q;

    logic word_wr, clr_wr;
    assign word_wr = cfg_we & ~cfg_addr;
    assign clr_wr  = cfg_we & cfg_addr & wr_clr;
    assign apply   = pend_q.valid & all_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q        <= {NDOM{RST_CODE}};
            pend_q.cfg   <= {NDOM{RST_CODE}};
            pend_q.valid <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            if (apply) begin
                act_q        <= pend_q.cfg;
                pend_q.valid <= 1'b0;
            end
            if (word_wr) begin
                if (wr_legal) begin
                    pend_q.cfg   <= wr_cfg;
                    pend_q.valid <= 1'b1;
                end else begin
                    err_q <= 1'b1;
                end
            end else if (clr_wr) begin
                err_q <= 1'b0;
            end
        end
    end

    assign act_cfg = act_q;
    assign use_cfg = apply ? pend_q.cfg : act_q;
    assign err     = err_q;
endmodule

// File: rtl/ckdiv_dom_counter.sv
module ckdiv_dom_counter
    import ckdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t code_use,
    output logic  strobe,
    output logic  high_half
);
    cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q >= code_last(code_use))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + cnt_t'(1);
    end

    assign strobe    = (cnt_q == '0);
    assign high_half = ({1'b0, cnt_q} < code_half(code_use));
endmodule

// File: rtl/ratio_clock_divider.sv
module ratio_clock_divider
    import ckdiv_pkg::*;
#(
    parameter code_t RST_CODE = SEL_DIV8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [NDOM-1:0]  strobe_o,
    output logic             ext_clk_o,
    output logic             cfg_err_o
);
    cfg_t            wr_cfg;
    cfg_t            act_cfg;
    cfg_t            use_cfg;
    logic            wr_legal, codes_ok, order_ok;
    logic            apply;
    logic [NDOM-1:0] strb;
    logic [NDOM-1:0] hi_half;

    assign wr_cfg = cfg_t'(cfg_wdata);

    ckdiv_rule_check u_rules (
        .cand     (wr_cfg),
        .legal    (wr_legal),
        .codes_ok (codes_ok),
        .order_ok (order_ok)
    );

    ckdiv_cfg_ctrl #(.RST_CODE(RST_CODE)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .wr_cfg   (wr_cfg),
        .wr_clr   (cfg_wdata[0]),
        .wr_legal (wr_legal),
        .all_zero (&strb),
        .act_cfg  (act_cfg),
        .use_cfg  (use_cfg),
        .apply    (apply),
        .err      (cfg_err_o)
    );

    for (genvar i = 0; i < NDOM; i++) begin : g_dom
        ckdiv_dom_counter u_cnt (
            .clk       (clk),
            .rst       (rst),
            .code_use  (use_cfg[i]),
            .strobe    (strb[i]),
            .high_half (hi_half[i])
        );
    end

    assign strobe_o  = strb;
    assign ext_clk_o = hi_half[D_BUS];
endmodule

// File: rtl/ckdiv_checker.sv
module ckdiv_checker
    import ckdiv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic             cfg_addr,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [NDOM-1:0]  strobe_o,
    input logic             ext_clk_o,
    input logic             cfg_err_o,
    input cfg_t             act_cfg
);
    cfg_t w;
    logic any_rsv;
    assign w = cfg_t'(cfg_wdata);

    always_comb begin
        any_rsv = 1'b0;
        for (int i = 0; i < NDOM; i++)
            if (w[i] > 3'b100) any_rsv = 1'b1;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (strobe_o == '1 && !cfg_err_o));

    a_r5_reserved_reject: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_addr && any_rsv) |=> (cfg_err_o && $stable(act_cfg)));

    a_r10_err_clear: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr && cfg_wdata[0]) |=> !cfg_err_o);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (cfg_err_o && !(cfg_we && cfg_addr && cfg_wdata[0])) |=> cfg_err_o);

    a_r6_bus_not_faster: assert property (@(posedge clk) disable iff (rst)
        code_div(act_cfg[D_BUS]) >= code_div(act_cfg[D_CORE]));

    a_r7_peri_not_faster: assert property (@(posedge clk) disable iff (rst)
        code_div(act_cfg[D_PERI]) >= code_div(act_cfg[D_BUS]));

    a_r4_apply_aligned: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_cfg) |-> $past(strobe_o == '1));

    a_r2_div1_steady: assert property (@(posedge clk) disable iff (rst)
        (act_cfg[D_CORE] == 3'b000 && $past(act_cfg[D_CORE] == 3'b000))
        |-> strobe_o[D_CORE]);

    a_r11_ext_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_clk_o) |-> strobe_o[D_BUS]);
endmodule

bind ratio_clock_divider ckdiv_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .strobe_o  (strobe_o),
    .ext_clk_o (ext_clk_o),
    .cfg_err_o (cfg_err_o),
    .act_cfg   (act_cfg)
);

// File: tb/tb_ratio_clock_divider.sv
module tb_ratio_clock_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [14:0] cfg_wdata = '0;
    logic [4:0]  strobe_o;
    logic        ext_clk_o;
    logic        cfg_err_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    ratio_clock_divider dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .strobe_o(strobe_o), .ext_clk_o(ext_clk_o),
        .cfg_err_o(cfg_err_o)
    );

    typedef struct packed {
        logic [4:0] strb;
        logic       ext;
        logic       err;
    } exp_t;

    exp_t exp_q[$];

    // reference model built from the requirements
    int       m_cnt[5];
    int       m_act[5];
    int       m_pend[5];
    bit       m_pv, m_err;

    function automatic int ratio_of(int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic bit word_ok(logic [14:0] w);
        int d[5];
        for (int i = 0; i < 5; i++) begin
            if (int'(w[3*i +: 3]) > 4) return 0;
            d[i] = ratio_of(int'(w[3*i +: 3]));
        end
        return d[1] >= d[0] && d[2] >= d[1] && d[3] >= d[0] &&
               d[3] <= d[4] && d[4] >= d[1] && d[4] <= d[2];
    endfunction

    always @(posedge clk) begin
        exp_t e;
        if (rst) begin
            for (int i = 0; i < 5; i++) begin
                m_cnt[i] = 0; m_act[i] = 4; m_pend[i] = 4;
            end
            m_pv = 0; m_err = 0;
        end else begin
            bit all0;
            all0 = 1;
            for (int i = 0; i < 5; i++) if (m_cnt[i] != 0) all0 = 0;
            if (m_pv && all0) begin
                for (int i = 0; i < 5; i++) m_act[i] = m_pend[i];
                m_pv = 0;
            end
            for (int i = 0; i < 5; i++)
                m_cnt[i] = (m_cnt[i] + 1) % ratio_of(m_act[i]);
            if (cfg_we && !cfg_addr) begin
                if (word_ok(cfg_wdata)) begin
                    for (int i = 0; i < 5; i++) m_pend[i] = int'(cfg_wdata[3*i +: 3]);
                    m_pv = 1;
                end else m_err = 1;
            end else if (cfg_we && cfg_addr && cfg_wdata[0]) m_err = 0;
        end
        for (int i = 0; i < 5; i++) e.strb[i] = (m_cnt[i] == 0);
        e.ext = m_cnt[1] < (ratio_of(m_act[1]) + 1) / 2;
        e.err = m_err;
        exp_q.push_back(e);
    end

    // monitor: compare at the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (strobe_o !== e.strb || ext_clk_o !== e.ext || cfg_err_o !== e.err) begin
                n_fail++;
                $display("FAIL %s t=%0t strobe=%b exp=%b ext=%b exp=%b err=%b exp=%b",
                         cur_req, $time, strobe_o, e.strb, ext_clk_o, e.ext,
                         cfg_err_o, e.err);
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [14:0] pack(int c, int b, int p, int f, int s);
        return {3'(s), 3'(f), 3'(p), 3'(b), 3'(c)};
    endfunction

    task automatic wr_word(string req, logic [14:0] w);
        @(negedge clk);
        cur_req = req;
        cfg_we = 1; cfg_addr = 0; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 0; cfg_wdata = '0;
    endtask

    task automatic wr_clear(string req, logic bit0);
        @(negedge clk);
        cur_req = req;
        cfg_we = 1; cfg_addr = 1; cfg_wdata = {14'd0, bit0};
        @(negedge clk);
        cfg_we = 0; cfg_addr = 0; cfg_wdata = '0;
    endtask

    task automatic explicit_chk(string req, logic got, logic want);
        n_tests++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s explicit got=%b exp=%b", req, got, want);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cur_req = "R1";
        explicit_chk("R1", cfg_err_o, 1'b0);
        explicit_chk("R1", &strobe_o, 1'b1);
        run(20);

        // R2 R4: core /1, bus /2, peri /4, fast /2, slow /4
        wr_word("R2/R4/R11", pack(0, 1, 3, 1, 3));
        run(40);
        explicit_chk("R2", strobe_o[0], 1'b1);

        // R3: odd ratio mix core /3 bus /3 peri /8 fast /4 slow /8
        wr_word("R3/R2/R11", pack(2, 2, 4, 3, 4));
        run(60);

        // R4: two accepted words before the common zero; the second wins
        wr_word("R4", pack(1, 1, 4, 2, 4));
        wr_word("R4", pack(0, 3, 4, 1, 4));
        run(60);

        // R5: reserved code in the peripheral field
        wr_word("R5", pack(0, 3, 5, 1, 4));
        explicit_chk("R5", cfg_err_o, 1'b1);
        run(30);

        // R10: bit0 = 0 keeps the flag, bit0 = 1 clears it
        wr_clear("R10", 1'b0);
        explicit_chk("R10", cfg_err_o, 1'b1);
        wr_clear("R10", 1'b1);
        explicit_chk("R10", cfg_err_o, 1'b0);

        wr_word("R6", pack(1, 0, 1, 1, 1));    // bus faster than core
        explicit_chk("R6", cfg_err_o, 1'b1);
        wr_clear("R10", 1'b1);
        wr_word("R7", pack(0, 3, 1, 1, 1));    // peri faster than bus
        explicit_chk("R7", cfg_err_o, 1'b1);
        wr_clear("R10", 1'b1);
        wr_word("R8", pack(1, 1, 4, 0, 4));    // fast timer faster than core
        explicit_chk("R8", cfg_err_o, 1'b1);
        wr_clear("R10", 1'b1);
        wr_word("R8", pack(0, 1, 4, 4, 3));    // fast timer slower than slow timer
        explicit_chk("R8", cfg_err_o, 1'b1);
        wr_clear("R10", 1'b1);
        wr_word("R9", pack(0, 3, 4, 0, 1));    // slow timer faster than bus
        explicit_chk("R9", cfg_err_o, 1'b1);
        wr_clear("R10", 1'b1);
        wr_word("R9", pack(0, 1, 3, 1, 4));    // slow timer slower than peri
        explicit_chk("R9", cfg_err_o, 1'b1);
        run(40);
        wr_clear("R10", 1'b1);

        // R11: bus /3 and /8 output shape, then back to all /8
        wr_word("R11", pack(0, 2, 2, 1, 2));
        run(40);
        wr_word("R11/R1", pack(4, 4, 4, 4, 4));
        run(60);

        done = 1;
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule